// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

A free-running 16-bit down-counter advances on every clock. Two event inputs pass through their own synchronisers and edge detectors. When the chosen edge arrives on an input, the counter value is latched into that input's capture register and the input's pending bit is set. Software uses the stored value to timestamp external events and to measure intervals. The latched value is exact, so the time software takes to respond does not affect it.

Each channel has its own edge polarity, its own pending bit and its own interrupt enable. A single interrupt output is the OR of the enabled pending bits. A simple register port lets software read both capture registers, the control word, the pending bits and the live counter value. None of these reads disturbs the count. Software can also load the counter and clear pending bits through the same port.

Top module: `icap_timer`

## Requirements
- R1: After reset the counter holds 0xFFFF. It decrements by one on every clock edge and wraps from 0x0000 to 0xFFFF without pausing.
- R2: A write to address 0 loads the counter with the write data on that edge, and counting resumes from there. A read of address 0 returns the current count and does not stop the counter.
- R3: Reads have a one-cycle latency. rdata holds its last value while rd_en is low. The address map is: 0 counter, 1 capture A, 2 capture B, 3 control, 4 pending. Any other address reads as zero. Control bit 0 is the polarity of A, bit 1 the polarity of B, bit 2 the enable of A and bit 3 the enable of B.
- R4: A qualifying edge on pin_a is sampled at clock edge k. At edge k+2, capture A takes the counter value that held between edges k+1 and k+2.
- R5: Channel B behaves in the same way on pin_b and capture B, independently of channel A.
- R6: A polarity bit of 0 selects the rising edge and 1 selects the falling edge. The opposite edge neither captures nor sets the pending bit.
- R7: Pending bit 0 belongs to A and bit 1 to B, and each is set by its channel's capture. Writing 1 to a bit of address 4 clears it. Writing 0 has no effect. A capture in the same cycle as a clear leaves the bit set.
- R8: A new trigger overwrites the capture register even while the pending bit is still set.
- R9: irq goes high one cycle after an enabled pending bit is set, and goes low one cycle after no enabled pending bit remains.
- R10: Edges that arrive on both pins in the same cycle make both channels capture the same counter value and set both pending bits.
- R11: After reset both capture registers, the control word and the pending bits read zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Asynchronous event input for channel A |
| pin_b | input | 1 | Asynchronous event input for channel B |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| irq | output | 1 | Interrupt request, registered |

## Verification
The assertions assume several things about the inputs:
- the event pins are low while reset is applied, so that leaving reset does not look like a rising edge;
- a read and a write are never issued in the same cycle;
- each pin level is held for at least three clocks, so that the synchroniser sees every transition.

The stimulus follows all three. It changes pins only half a period away from the clock edge, keeps every level for three or more cycles, and always finishes one register access before it starts the next.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [2:0] {
    RA_COUNT = 3'd0,
    RA_CAPA  = 3'd1,
    RA_CAPB  = 3'd2,
    RA_CTRL  = 3'd3,
    RA_PEND  = 3'd4
  } reg_addr_e;

  localparam int NUM_CH     = 2;
  localparam int CTL_POL_LSB = 0;
  localparam int CTL_EN_LSB  = NUM_CH;
  localparam int CTL_W       = 2 * NUM_CH;
endpackage

// File: rtl/icap_free_counter.sv
module icap_free_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] STEP = W'(1);

  always_ff @(posedge clk) begin
    if (rst)       count <= '1;
    else if (load) count <= load_val;
    else           count <= count - STEP;
  end
endmodule

// File: rtl/icap_edge_sync.sv
module icap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic falling,
  output logic evt
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_lvl <= 1'b0;
    else     last_lvl <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];

  always_comb begin
    if (falling) evt = last_lvl & ~lvl;
    else         evt = lvl & ~last_lvl;
  end
endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic [W-1:0] count,
  input  logic         clr,
  output logic [W-1:0] cap,
  output logic         pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap  <= '0;
      pend <= 1'b0;
    end else begin
      if (evt) cap <= count;
      if (evt)      pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_timer.sv
module icap_timer
  import icap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_a,
  input  logic          pin_b,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] rdata,
  output logic          irq
);
  localparam int PAD_PEND = TW - NUM_CH;
  localparam int PAD_CTL  = TW - CTL_W;

  logic [TW-1:0]     timer_q;
  logic              tmr_wr, ctl_wr, pnd_wr;
  logic [CTL_W-1:0]  ctrl_q;
  logic [NUM_CH-1:0] pol, en, evt, pend, pins;
  logic [TW-1:0]     cap [NUM_CH];

  assign tmr_wr = wr_en && (addr == AW'(RA_COUNT));
  assign ctl_wr = wr_en && (addr == AW'(RA_CTRL));
  assign pnd_wr = wr_en && (addr == AW'(RA_PEND));
  assign pins   = {pin_b, pin_a};
  assign pol    = ctrl_q[CTL_POL_LSB +: NUM_CH];
  assign en     = ctrl_q[CTL_EN_LSB  +: NUM_CH];

  icap_free_counter #(.W(TW)) u_cnt (
    .clk(clk), .rst(rst), .load(tmr_wr), .load_val(wdata), .count(timer_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (ctl_wr) ctrl_q <= wdata[CTL_W-1:0];
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      icap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(pins[ch]), .falling(pol[ch]), .evt(evt[ch])
      );
      icap_channel #(.W(TW)) u_cap (
        .clk(clk), .rst(rst), .evt(evt[ch]), .count(timer_q),
        .clr(pnd_wr && wdata[ch]), .cap(cap[ch]), .pend(pend[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        AW'(RA_COUNT): rdata <= timer_q;
        AW'(RA_CAPA):  rdata <= cap[0];
        AW'(RA_CAPB):  rdata <= cap[1];
        AW'(RA_CTRL):  rdata <= {{PAD_CTL{1'b0}}, ctrl_q};
        AW'(RA_PEND):  rdata <= {{PAD_PEND{1'b0}}, pend};
        default:       rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & en);
  end
endmodule

// File: rtl/icap_timer_chk.sv
module icap_timer_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] timer_q,
  input logic          tmr_wr,
  input logic          pnd_wr,
  input logic [1:0]    wdata_lo,
  input logic [1:0]    evt,
  input logic [1:0]    pend,
  input logic [1:0]    en,
  input logic [TW-1:0] cap_a,
  input logic [TW-1:0] cap_b,
  input logic          rd_en,
  input logic [TW-1:0] rdata,
  input logic          irq
);
  localparam logic [TW-1:0] ONE = TW'(1);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tmr_wr)) |-> (timer_q == $past(timer_q) - ONE));

  // R4
  cap_a_value_chk: assert property (@(posedge clk) disable iff (rst)
    evt[0] |=> (cap_a == $past(timer_q)));

  // R5
  cap_b_value_chk: assert property (@(posedge clk) disable iff (rst)
    evt[1] |=> (cap_b == $past(timer_q)));

  // R7
  pend_a_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[0]) |-> $past(evt[0]));

  // R7
  pend_b_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[1]) |-> $past(evt[1]));

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pnd_wr) && $past(wdata_lo[0]) && !$past(evt[0])) |-> !pend[0]);

  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend & en) == 2'b00) |-> !irq);

  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend & en) != 2'b00) |-> irq);

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));
endmodule

bind icap_timer icap_timer_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .timer_q(timer_q), .tmr_wr(tmr_wr), .pnd_wr(pnd_wr),
  .wdata_lo(wdata[1:0]), .evt(evt), .pend(pend), .en(en),
  .cap_a(cap[0]), .cap_b(cap[1]), .rd_en(rd_en), .rdata(rdata), .irq(irq)
);

// File: tb/test_icap_timer.sv
module test_icap_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_a = 1'b0, pin_b = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] model;
  logic [15:0] exp_t, ea, eb;
  logic        rd_q;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  icap_timer i_icap_timer (
    .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // Counter model taken from R1/R2
  always @(posedge clk) begin
    if (rst)                      model <= 16'hFFFF;
    else if (wr_en && addr == 3'd0) model <= wdata;
    else                          model <= model - 16'd1;
    rd_q <= rd_en && !rst;
  end

  // Scoreboard monitor: each read response is compared with the queued item
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL read response with no expectation act=%h", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk1(input string tag, input logic act, input logic e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic use_model,
                    input logic [15:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(use_model ? model : e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Pins sampled at edge k; capture takes the count held between k+1 and k+2 (R4)
  task automatic set_pins(input logic a, input logic b);
    @(negedge clk);
    pin_a = a; pin_b = b;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp_t = model;
  endtask

  initial begin : watchdog
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11 reset state, R2 live count
    rd(3'd0, 1'b1, 16'h0, "R2 count read");
    rd(3'd1, 1'b0, 16'h0, "R11 capA reset");
    rd(3'd2, 1'b0, 16'h0, "R11 capB reset");
    rd(3'd3, 1'b0, 16'h0, "R11 ctrl reset");
    rd(3'd4, 1'b0, 16'h0, "R11 pend reset");
    chk1("R11 irq reset", irq, 1'b0);

    // R1 wrap, R2 load
    wr(3'd0, 16'h0000);
    rd(3'd0, 1'b0, 16'hFFFF, "R1 wrap");
    wr(3'd0, 16'h0100);
    rd(3'd0, 1'b0, 16'h00FF, "R2 load");
    rd(3'd5, 1'b0, 16'h0, "R3 unmapped");

    // Channel A rising, enabled
    wr(3'd3, 16'h0004);
    set_pins(1'b1, 1'b0); ea = exp_t;
    idle(3);
    chk1("R9 irq on enabled pend", irq, 1'b1);
    rd(3'd4, 1'b0, 16'h0001, "R7 pend A set");
    rd(3'd1, 1'b0, ea, "R4 capture A");
    rd(3'd3, 1'b0, 16'h0004, "R3 ctrl readback");
    idle(2);
    chk1("R3 rdata hold", rdata == 16'h0004, 1'b1);

    wr(3'd4, 16'h0001);
    idle(1);
    chk1("R9 irq drop", irq, 1'b0);
    rd(3'd4, 1'b0, 16'h0, "R7 clear");

    // Opposite edge ignored
    set_pins(1'b0, 1'b0); idle(2);
    rd(3'd4, 1'b0, 16'h0, "R6 falling ignored pend");
    rd(3'd1, 1'b0, ea, "R6 falling ignored cap");

    // Falling polarity on A
    wr(3'd3, 16'h0005);
    set_pins(1'b1, 1'b0); idle(2);
    rd(3'd4, 1'b0, 16'h0, "R6 rising ignored");
    set_pins(1'b0, 1'b0); ea = exp_t; idle(2);
    rd(3'd1, 1'b0, ea, "R6 falling capture");
    rd(3'd4, 1'b0, 16'h0001, "R7 pend on falling");

    // Channel B, not enabled
    wr(3'd4, 16'h0001);
    set_pins(1'b0, 1'b1); eb = exp_t; idle(3);
    chk1("R9 irq masked B", irq, 1'b0);
    rd(3'd2, 1'b0, eb, "R5 capture B");
    rd(3'd1, 1'b0, ea, "R5 A untouched");
    rd(3'd4, 1'b0, 16'h0002, "R5 pend B");
    wr(3'd4, 16'h0000);
    rd(3'd4, 1'b0, 16'h0002, "R7 write zero no effect");

    // Overwrite while pending
    set_pins(1'b0, 1'b0);
    set_pins(1'b0, 1'b1); eb = exp_t; idle(2);
    rd(3'd2, 1'b0, eb, "R8 overwrite B");

    // Simultaneous capture
    wr(3'd3, 16'h000C);
    wr(3'd4, 16'h0003);
    set_pins(1'b0, 1'b0);
    set_pins(1'b1, 1'b1); ea = exp_t; idle(3);
    chk1("R10 irq both", irq, 1'b1);
    rd(3'd1, 1'b0, ea, "R10 capA");
    rd(3'd2, 1'b0, ea, "R10 capB");
    rd(3'd4, 1'b0, 16'h0003, "R10 pend both");

    // Capture beats a clear on the same edge
    wr(3'd4, 16'h0003);
    set_pins(1'b0, 1'b0); idle(2);
    set_pins(1'b1, 1'b0); ea = exp_t;
    wr_en = 1'b1; addr = 3'd4; wdata = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd4, 1'b0, 16'h0001, "R7 set wins over clear");
    rd(3'd1, 1'b0, ea, "R7 capture with clear");
    rd(3'd0, 1'b1, 16'h0, "R2 count still running");

    idle(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule